// File: doc/BRIEF.md
# Garage Door Motion Controller

This block drives the motor of a garage door from two push buttons (one on the wall, one from a remote receiver), two end-of-travel switches, and an infrared safety beam across the opening. It decides when the door moves, in which direction, and when it stops or reverses. After every completed opening or closing run it also keeps the garage light on for a programmable period.

The two buttons are treated as one command source. The block takes synchronous, already debounced levels and finds the rising edge itself. One press starts the door if it is at rest and stops it if it is moving. The press after a stop sends the door back the way it came.

The light period is counted in ticks of an external prescaler enable. A one-second tick with the default of 300 ticks gives five minutes. The motor outputs come straight from the state register.

States:
- `ST_BOOT`: the one cycle after reset.
- `ST_CLOSED`: at rest, closed.
- `ST_OPEN`: at rest, open.
- `ST_OPENING`: moving up.
- `ST_CLOSING`: moving down.
- `ST_HOLD_UP`: halted, next move is up.
- `ST_HOLD_DN`: halted, next move is down.
- `ST_REVERSE`: a one-cycle pause after a beam break.

Transitions:
- boot→closed when the bottom switch is active.
- boot→hold_up otherwise.
- closed→opening on a press.
- open→closing on a press.
- opening→open on the top switch.
- opening→hold_dn on a press.
- closing→closed on the bottom switch.
- closing→reverse on a beam break.
- closing→hold_up on a press.
- reverse→opening unconditionally.
- hold_up→opening on a press.
- hold_dn→closing on a press.

Top module: `garage_door_ctrl`

## Requirements
- R1: A rising edge on `btn_wall` or on `btn_remote` is one press. A button held high gives only the one press at its rising edge, and the state moves on the clock edge that samples that rise.
- R2: A press in `ST_CLOSED` or `ST_HOLD_UP` drives `motor_up`. A press in `ST_OPEN` or `ST_HOLD_DN` drives `motor_dn`.
- R3: A press while the door moves turns both motor outputs off. The next press drives the motor the opposite way.
- R4: `lim_top` ends upward motion into `ST_OPEN`, and `lim_bot` ends downward motion into `ST_CLOSED`. A press in the same cycle as the matching limit switch is ignored.
- R5: `beam_cut` while closing turns both motors off for exactly one cycle, then `motor_up` rises. The beam takes priority over a press in the same cycle. It has no effect in any other state.
- R6: `light_on` rises in the cycle after a completed run. It stays high until `LIGHT_TICKS` cycles with `tick` high have passed. Each new completion reloads the full period, and a tick in the cycle of completion is not counted.
- R7: `motor_up` and `motor_dn` are never high together. Neither one ever rises in the cycle after the other was high.
- R8: After reset, both motors and the light are off. A button held through reset gives no press. The first press moves the door up, whether or not the bottom switch is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Prescaler enable that paces the light timer |
| btn_wall | input | 1 | Wall button level |
| btn_remote | input | 1 | Remote button level |
| lim_top | input | 1 | Door fully open switch |
| lim_bot | input | 1 | Door fully closed switch |
| beam_cut | input | 1 | Infrared beam interrupted |
| motor_up | output | 1 | Drive door upward |
| motor_dn | output | 1 | Drive door downward |
| light_on | output | 1 | Garage light |

## Verification
The bench targets a press that coincides with a limit switch. A design that let the press win would halt the door one step short of its end stop and never start the light. It also targets a beam break that coincides with a press. A design that honoured the press would leave the door halted over an obstruction instead of reopening it. The light timer is probed with a tick arriving in the cycle of completion and with a completion that arrives while the light is still counting down. An off-by-one or a missing reload shows up as a light that goes out one tick early or too soon. Buttons held across reset and across several cycles are used to catch a level-sensitive press decoder, which would start the door on its own.

// File: rtl/gd_pkg.sv
package gd_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_CLOSED,
        ST_OPEN,
        ST_OPENING,
        ST_CLOSING,
        ST_HOLD_UP,
        ST_HOLD_DN,
        ST_REVERSE
    } door_state_e;
endpackage

// File: rtl/gd_press_detect.sv
module gd_press_detect #(
    parameter int N_BTN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_BTN-1:0] btn,
    output logic             press
);
    logic [N_BTN-1:0] prev_q;
    logic [N_BTN-1:0] rise;

    // prev resets high: a button held through reset is not a press
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= btn;
    end

    generate
        for (genvar i = 0; i < N_BTN; i++) begin : g_edge
            assign rise[i] = btn[i] & ~prev_q[i];
        end
    endgenerate

    assign press = |rise;
endmodule

// File: rtl/gd_motion_fsm.sv
module gd_motion_fsm
    import gd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic press,
    input  logic lim_top,
    input  logic lim_bot,
    input  logic beam_cut,
    output logic motor_up,
    output logic motor_dn,
    output logic run_done
);
    door_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT;
        else        state_q <= state_d;
    end

    // next state; limit switch beats beam, beam beats press
    always_comb begin
        state_d  = state_q;
        run_done = 1'b0;
        unique case (state_q)
            ST_BOOT:    state_d = lim_bot ? ST_CLOSED : ST_HOLD_UP;
            ST_CLOSED:  if (press) state_d = ST_OPENING;
            ST_OPEN:    if (press) state_d = ST_CLOSING;
            ST_HOLD_UP: if (press) state_d = ST_OPENING;
            ST_HOLD_DN: if (press) state_d = ST_CLOSING;
            ST_OPENING: begin
                if (lim_top) begin
                    state_d  = ST_OPEN;
                    run_done = 1'b1;
                end else if (press) begin
                    state_d = ST_HOLD_DN;
                end
            end
            ST_CLOSING: begin
                if (lim_bot) begin
                    state_d  = ST_CLOSED;
                    run_done = 1'b1;
                end else if (beam_cut) begin
                    state_d = ST_REVERSE;
                end else if (press) begin
                    state_d = ST_HOLD_UP;
                end
            end
            ST_REVERSE: state_d = ST_OPENING;
            default:    state_d = ST_BOOT;
        endcase
    end

    // outputs from state only
    always_comb begin
        motor_up = 1'b0;
        motor_dn = 1'b0;
        unique case (state_q)
            ST_OPENING: motor_up = 1'b1;
            ST_CLOSING: motor_dn = 1'b1;
            default: begin
                motor_up = 1'b0;
                motor_dn = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/gd_light_timer.sv
module gd_light_timer #(
    parameter int LIGHT_TICKS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic tick,
    output logic light_on
);
    localparam int CW = $clog2(LIGHT_TICKS + 1);
    localparam logic [CW-1:0] LOAD = CW'(LIGHT_TICKS);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         remain_q <= '0;
        else if (start)                     remain_q <= LOAD;
        else if (tick && remain_q != '0)    remain_q <= remain_q - 1'b1;
    end

    assign light_on = (remain_q != '0);
endmodule

// File: rtl/garage_door_ctrl.sv
module garage_door_ctrl #(
    parameter int LIGHT_TICKS = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_wall,
    input  logic btn_remote,
    input  logic lim_top,
    input  logic lim_bot,
    input  logic beam_cut,
    output logic motor_up,
    output logic motor_dn,
    output logic light_on
);
    logic press;
    logic run_done;

    gd_press_detect #(.N_BTN(2)) u_press (
        .clk   (clk),
        .rst_n (rst_n),
        .btn   ({btn_remote, btn_wall}),
        .press (press)
    );

    gd_motion_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .press    (press),
        .lim_top  (lim_top),
        .lim_bot  (lim_bot),
        .beam_cut (beam_cut),
        .motor_up (motor_up),
        .motor_dn (motor_dn),
        .run_done (run_done)
    );

    gd_light_timer #(.LIGHT_TICKS(LIGHT_TICKS)) u_light (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (run_done),
        .tick     (tick),
        .light_on (light_on)
    );
endmodule

// File: rtl/gd_checker.sv
module gd_checker (
    input logic clk,
    input logic rst_n,
    input logic lim_top,
    input logic lim_bot,
    input logic beam_cut,
    input logic motor_up,
    input logic motor_dn,
    input logic light_on
);
    assert_never_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(motor_up && motor_dn));

    assert_gap_after_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        motor_dn |=> !motor_up);

    assert_gap_after_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        motor_up |=> !motor_dn);

    assert_top_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_up && lim_top) |=> (!motor_up && !motor_dn));

    assert_bot_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_dn && lim_bot) |=> (!motor_dn && !motor_up));

    assert_beam_reverse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_dn && beam_cut && !lim_bot) |=> (!motor_dn && !motor_up) ##1 motor_up);

    assert_light_after_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_up && lim_top) |=> light_on);

    assert_light_after_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_dn && lim_bot) |=> light_on);
endmodule

bind garage_door_ctrl gd_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lim_top  (lim_top),
    .lim_bot  (lim_bot),
    .beam_cut (beam_cut),
    .motor_up (motor_up),
    .motor_dn (motor_dn),
    .light_on (light_on)
);

// File: tb/garage_door_ctrl_test.sv
module garage_door_ctrl_test;
    localparam int LT = 3;
    localparam int NV = 35;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, btn_wall = 1'b0, btn_remote = 1'b0;
    logic lim_top = 1'b0, lim_bot = 1'b0, beam_cut = 1'b0;
    logic motor_up, motor_dn, light_on;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    garage_door_ctrl #(.LIGHT_TICKS(LT)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .btn_wall(btn_wall), .btn_remote(btn_remote),
        .lim_top(lim_top), .lim_bot(lim_bot), .beam_cut(beam_cut),
        .motor_up(motor_up), .motor_dn(motor_dn), .light_on(light_on)
    );

    // {req[3:0], wall, remote, top, bot, beam, tick, exp_up, exp_dn, exp_light}
    localparam logic [12:0] VEC [NV] = '{
        {4'd8, 9'b000100_000}, // 0  R8 closed at rest
        {4'd2, 9'b100100_100}, // 1  R2 press from closed -> up
        {4'd1, 9'b100000_100}, // 2  R1 held, no new press
        {4'd1, 9'b000000_100}, // 3
        {4'd4, 9'b001000_001}, // 4  R4 top ends, light
        {4'd6, 9'b001001_001}, // 5  R6 tick 1
        {4'd6, 9'b001001_001}, // 6  tick 2
        {4'd6, 9'b001001_000}, // 7  tick 3 off
        {4'd2, 9'b011000_010}, // 8  R2 remote from open -> down
        {4'd2, 9'b000000_010}, // 9
        {4'd5, 9'b000010_000}, // 10 R5 beam -> pause
        {4'd5, 9'b000010_100}, // 11 R5 then up, beam ignored
        {4'd3, 9'b100000_000}, // 12 R3 stop while up
        {4'd3, 9'b000000_000}, // 13
        {4'd3, 9'b010000_010}, // 14 R3 next goes down
        {4'd3, 9'b000000_010}, // 15
        {4'd3, 9'b100000_000}, // 16 R3 stop while down
        {4'd3, 9'b000000_000}, // 17
        {4'd3, 9'b100000_100}, // 18 R3 next goes up
        {4'd3, 9'b000000_100}, // 19
        {4'd4, 9'b101000_001}, // 20 R4 press with top ignored
        {4'd4, 9'b001000_001}, // 21
        {4'd2, 9'b101000_011}, // 22 R2 close, light still on
        {4'd6, 9'b000101_001}, // 23 R6 reload, tick ignored
        {4'd6, 9'b000101_001}, // 24
        {4'd6, 9'b000100_001}, // 25 no tick
        {4'd6, 9'b000101_001}, // 26
        {4'd6, 9'b000101_000}, // 27 off
        {4'd2, 9'b010100_100}, // 28 R2 up
        {4'd2, 9'b000000_100}, // 29
        {4'd4, 9'b001000_001}, // 30
        {4'd2, 9'b101000_011}, // 31
        {4'd2, 9'b000000_011}, // 32
        {4'd5, 9'b100010_001}, // 33 R5 beam beats press
        {4'd5, 9'b000000_101}  // 34 up after pause
    };

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s up/dn/light actual=%b expected=%b", req, act, exp_v);
        end
    endtask

    task automatic drive(input logic [5:0] v);
        @(negedge clk);
        {btn_wall, btn_remote, lim_top, lim_bot, beam_cut, tick} = v;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic bot, input logic btn);
        @(negedge clk);
        rst_n = 1'b0;
        {btn_wall, btn_remote, lim_top, beam_cut, tick} = '0;
        btn_wall = btn;
        lim_bot = bot;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R8 reset with bottom active
        do_reset(1'b1, 1'b0);
        #1 check("R8", {motor_up, motor_dn, light_on}, 3'b000);
        drive(6'b000100);
        check("R8", {motor_up, motor_dn, light_on}, 3'b000);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][8:3]);
            check($sformatf("R%0d vec%0d", VEC[i][12:9], i),
                  {motor_up, motor_dn, light_on}, VEC[i][2:0]);
        end

        // R8 reset away from bottom, button held through reset
        do_reset(1'b0, 1'b1);
        #1 check("R8", {motor_up, motor_dn, light_on}, 3'b000);
        drive(6'b100000);
        check("R8 held", {motor_up, motor_dn, light_on}, 3'b000);
        drive(6'b100000);
        check("R8 held", {motor_up, motor_dn, light_on}, 3'b000);
        // R5 beam while halted has no effect
        drive(6'b000010);
        check("R5 idle beam", {motor_up, motor_dn, light_on}, 3'b000);
        drive(6'b000000);
        check("R5 idle beam", {motor_up, motor_dn, light_on}, 3'b000);
        // R8 first press goes up
        drive(6'b010000);
        check("R8 first up", {motor_up, motor_dn, light_on}, 3'b000 | 3'b100);
        // R4 bottom switch has no effect while going up
        drive(6'b000100);
        check("R4 bot ignored up", {motor_up, motor_dn, light_on}, 3'b100);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule